// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block multiplies or divides two 32-bit integers over many clock cycles. A single shift and add/subtract step serves both jobs. Multiplication adds the multiplicand into an upper accumulator whenever the low bit of the multiplier is set, then shifts. Division is restoring: each step shifts one dividend bit into the partial remainder and tries a subtraction of the divisor. It keeps the difference and records a 1 when the difference is not negative. Otherwise it keeps the old partial remainder and records a 0. Signed operations run on magnitudes, and a final cycle corrects the signs.

The results go into two 32-bit result registers, HI and LO, which can be read at any time. A multiply leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO. The caller pulses a start strobe together with an operation code and two operands. It then waits for the one-cycle done pulse. Overflow is not detected, and a divide by zero raises no error.

Top module: `md_unit`

## Requirements
- R1: After reset, busy and done are 0 and both HI and LO read 0.
- R2: Operation code 01 (unsigned multiply) leaves the upper 32 bits of the 64-bit unsigned product in HI and the lower 32 bits in LO.
- R3: Operation code 00 (signed multiply) treats both operands as two's complement. HI:LO holds the exact 64-bit signed product.
- R4: Operation code 11 (unsigned divide) with a nonzero divisor leaves the quotient in LO and the remainder in HI.
- R5: Operation code 10 (signed divide) with a nonzero divisor truncates the quotient toward zero. The quotient's sign is the XOR of the operand signs, and the remainder takes the sign of the dividend. A most-negative dividend divided by -1 yields a quotient of 0x80000000 and a remainder of 0.
- R6: A zero divisor still completes with normal timing and leaves the dividend in HI. LO reads 0xFFFFFFFF, except for a signed divide of a negative dividend, where LO reads 1.
- R7: A start strobe sampled while idle raises busy on the next cycle. Busy stays high for exactly 34 cycles: one setup, 32 iterations and one sign fix. Done is high for exactly the one cycle in which busy has just fallen, and the new HI/LO values are visible in that same cycle.
- R8: A start strobe while busy is ignored, and so are operand or code changes after acceptance. The running operation finishes with its original result, and no second operation follows.
- R9: HI and LO change only in the cycle that done is high. They hold their values while busy and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts an operation when sampled high while idle |
| op_i | input | 2 | Operation code: bit 1 = divide, bit 0 = unsigned |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while an operation is running |
| done_o | output | 1 | One-cycle pulse when results are written |
| hi_o | output | 32 | HI result register |
| lo_o | output | 32 | LO result register |

## Verification
The hardest case to reach is a start strobe, with new operands and a new code, arriving in the middle of a running operation. The stimulus drives exactly that, ten cycles into selected operations. It then checks that the cycle count, HI and LO all match the first request. It also checks that busy stays low afterwards. The sign-correction corners are covered by sweeping every pair from a small set of edge values under all four codes. That set includes the most-negative value, -1, 0 and the largest positive value. The sweep therefore includes zero divisors and the one signed quotient that overflows.

// File: rtl/md_pkg.sv
package md_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FIX
    } md_state_e;

    // sign-correction plan captured in the setup cycle
    typedef struct packed {
        logic is_div;
        logic neg_main;   // product or quotient must be negated
        logic neg_rem;    // remainder must be negated
    } md_fix_t;

    function automatic logic op_is_div(md_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_signed(md_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
    import md_pkg::*;
#(
    parameter int unsigned ITERS = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    output md_state_e state_o,
    output logic      done_o
);
    localparam int unsigned CW = $clog2(ITERS);

    md_state_e       state_q;
    logic [CW-1:0]   cnt_q;
    logic            done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE:  if (start_i) state_q <= ST_SETUP;
                ST_SETUP: begin
                    state_q <= ST_ITER;
                    cnt_q   <= '0;
                end
                ST_ITER: begin
                    if (cnt_q == CW'(ITERS - 1)) state_q <= ST_FIX;
                    else                         cnt_q   <= cnt_q + 1'b1;
                end
                ST_FIX: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign done_o  = done_q;
endmodule

// File: rtl/md_step.sv
module md_step #(
    parameter int unsigned XLEN = 32
) (
    input  logic            div_i,
    input  logic [XLEN:0]   up_i,
    input  logic [XLEN-1:0] lo_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN:0]   up_o,
    output logic [XLEN-1:0] lo_o
);
    logic [XLEN+1:0] opa, opb, sum;
    logic [XLEN:0]   mid;
    logic            take;

    always_comb begin
        if (div_i) begin
            opa = {1'b0, up_i[XLEN-1:0], lo_i[XLEN-1]};
            opb = ~{2'b00, b_i};
        end else begin
            opa = {1'b0, up_i};
            opb = {2'b00, b_i};
        end
        // one adder: add for multiply, subtract (invert + carry-in) for divide
        sum = opa + opb + {{(XLEN+1){1'b0}}, div_i};

        if (div_i) begin
            take = ~sum[XLEN+1];                    // trial difference not negative
            mid  = take ? sum[XLEN:0] : opa[XLEN:0]; // restore on negative
            up_o = mid;
            lo_o = {lo_i[XLEN-2:0], take};
        end else begin
            take = lo_i[0];
            mid  = take ? sum[XLEN:0] : up_i;
            up_o = {1'b0, mid[XLEN:1]};
            lo_o = {mid[0], lo_i[XLEN-1:1]};
        end
    end
endmodule

// File: rtl/md_unit.sv
module md_unit
    import md_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);
    localparam int unsigned ITERS = XLEN;
    localparam int unsigned PW    = 2 * XLEN;

    md_state_e       state;
    md_op_e          op_q;
    md_fix_t         fix_q;
    logic [XLEN-1:0] a_q, b_q, bm_q, lo_q, hi_res_q, lo_res_q;
    logic [XLEN:0]   up_q;
    logic [XLEN:0]   step_up;
    logic [XLEN-1:0] step_lo;
    logic            sa, sb;
    logic [PW-1:0]   prod_mag, prod_fix;
    logic [XLEN-1:0] quo_fix, rem_fix;

    md_ctrl #(.ITERS(ITERS)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .state_o (state),
        .done_o  (done_o)
    );

    md_step #(.XLEN(XLEN)) step_i (
        .div_i (fix_q.is_div),
        .up_i  (up_q),
        .lo_i  (lo_q),
        .b_i   (bm_q),
        .up_o  (step_up),
        .lo_o  (step_lo)
    );

    always_comb begin
        sa       = op_is_signed(op_q) & a_q[XLEN-1];
        sb       = op_is_signed(op_q) & b_q[XLEN-1];
        prod_mag = {up_q[XLEN-1:0], lo_q};
        prod_fix = fix_q.neg_main ? -prod_mag : prod_mag;
        quo_fix  = fix_q.neg_main ? -lo_q : lo_q;
        rem_fix  = fix_q.neg_rem ? -up_q[XLEN-1:0] : up_q[XLEN-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= OP_MULS;
            a_q      <= '0;
            b_q      <= '0;
            bm_q     <= '0;
            up_q     <= '0;
            lo_q     <= '0;
            fix_q    <= '0;
            hi_res_q <= '0;
            lo_res_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q <= md_op_e'(op_i);
                        a_q  <= opa_i;
                        b_q  <= opb_i;
                    end
                end
                ST_SETUP: begin
                    up_q           <= '0;
                    lo_q           <= sa ? -a_q : a_q;
                    bm_q           <= sb ? -b_q : b_q;
                    fix_q.is_div   <= op_is_div(op_q);
                    fix_q.neg_main <= sa ^ sb;
                    fix_q.neg_rem  <= op_is_div(op_q) ? sa : 1'b0;
                end
                ST_ITER: begin
                    up_q <= step_up;
                    lo_q <= step_lo;
                end
                ST_FIX: begin
                    if (fix_q.is_div) begin
                        hi_res_q <= rem_fix;
                        lo_res_q <= quo_fix;
                    end else begin
                        hi_res_q <= prod_fix[PW-1:XLEN];
                        lo_res_q <= prod_fix[XLEN-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state != ST_IDLE);
    assign hi_o   = hi_res_q;
    assign lo_o   = lo_res_q;
endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] hi_o,
    input logic [XLEN-1:0] lo_o
);
    localparam int unsigned RUN = XLEN + 2;
    localparam int unsigned RW  = $clog2(RUN + 2) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == RW'(RUN)));

    p_done_at_fall_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_start_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_busy_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind md_unit md_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/md_unit_tb_top.sv
module md_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_s = 2'b00;
    logic [31:0] a_s = '0, b_s = '0;
    logic        busy, done;
    logic [31:0] hi, lo;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    md_unit #(.XLEN(32)) dut_i (
        .clk (clk), .rst (rst), .start_i (start), .op_i (op_s),
        .opa_i (a_s), .opb_i (b_s), .busy_o (busy), .done_o (done),
        .hi_o (hi), .lo_o (lo)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    function automatic void model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] eh, output logic [31:0] el);
        longint      sp, sq, sr;
        logic [63:0] up;
        case (op)
            2'b00: begin
                sp = longint'($signed(a)) * longint'($signed(b));
                eh = sp[63:32]; el = sp[31:0];
            end
            2'b01: begin
                up = {32'b0, a} * {32'b0, b};
                eh = up[63:32]; el = up[31:0];
            end
            2'b10: begin
                if (b == 0) begin
                    eh = a; el = a[31] ? 32'd1 : 32'hFFFF_FFFF;
                end else begin
                    sq = longint'($signed(a)) / longint'($signed(b));
                    sr = longint'($signed(a)) % longint'($signed(b));
                    eh = sr[31:0]; el = sq[31:0];
                end
            end
            default: begin
                if (b == 0) begin
                    eh = a; el = 32'hFFFF_FFFF;
                end else begin
                    eh = a % b; el = a / b;
                end
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] op, input logic [31:0] b);
        case (op)
            2'b00:   return "R3 signed multiply";
            2'b01:   return "R2 unsigned multiply";
            2'b10:   return (b == 0) ? "R6 signed zero divisor" : "R5 signed divide";
            default: return (b == 0) ? "R6 unsigned zero divisor" : "R4 unsigned divide";
        endcase
    endfunction

    // runs one operation; inject pulses a second start mid-run with other operands
    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic inject);
        logic [31:0] ph, pl, eh, el;
        int cyc;
        string t;
        ph = hi; pl = lo;
        model(op, a, b, eh, el);
        t = tag_of(op, b);
        @(negedge clk);
        start = 1'b1; op_s = op; a_s = a; b_s = b;
        @(negedge clk);
        start = 1'b0; cyc = 1;
        chk("R7 busy after start", {31'b0, busy}, 32'd1);
        while (!done && cyc < 100) begin
            if (inject && cyc == 10) begin
                start = 1'b1; a_s = ~a; b_s = b + 32'd1; op_s = op ^ 2'b11;
            end else begin
                start = 1'b0;
            end
            if (cyc == 17) begin
                chk("R9 HI held while busy", hi, ph);
                chk("R9 LO held while busy", lo, pl);
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        // start sampled at edge 0; done visible after edge 34 -> 35 edges counted
        chk("R7 cycles to done", 32'(cyc), 32'd35);
        chk("R7 busy low with done", {31'b0, busy}, 32'd0);
        chk({t, " HI"}, hi, eh);
        chk({t, " LO"}, lo, el);
        if (inject) begin
            ph = hi; pl = lo;
            repeat (20) @(negedge clk);
            chk("R8 no second operation", {30'b0, busy, done}, 32'd0);
            chk("R8 R9 HI unchanged after ignored start", hi, ph);
            chk("R8 R9 LO unchanged after ignored start", lo, pl);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R7 watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [12];
        logic [31:0] rnd;
        vals = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd7, 32'hFFFF_FFFF, 32'hFFFF_FFF9,
                 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF, 32'hFFFF_FFFE};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", {31'b0, busy}, 32'd0);
        chk("R1 done after reset", {31'b0, done}, 32'd0);
        chk("R1 HI after reset", hi, 32'd0);
        chk("R1 LO after reset", lo, 32'd0);

        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run_op(2'(op), vals[i], vals[j], 1'b0);

        rnd = 32'h1357_9BDF;
        for (int k = 0; k < 240; k++) begin
            logic [31:0] ra, rb;
            rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
            ra = rnd;
            rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
            rb = (k % 3 == 0) ? (rnd >> (k % 29)) : rnd;
            run_op(2'(k % 4), ra, rb, (k % 20) == 0);
        end

        // R8: mid-run restarts on each code, including a zero divisor
        run_op(2'b00, 32'hFFFF_FFF9, 32'd6, 1'b1);
        run_op(2'b01, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1);
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        run_op(2'b11, 32'd1000, 32'd0, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule